// File: doc/BRIEF.md
# FIFO flag offset register loader

This block keeps the two threshold offsets that a FIFO's flag logic compares against: `n`, the distance from empty at which the almost-empty flag fires, and `m`, the distance from full at which the almost-full flag fires. Both are presented continuously on dedicated outputs, so the comparator next to this block can read them directly.

While the active-low master reset is held, three strap inputs are sampled on every clock. One bit chooses how the offsets are loaded until the next reset: either one bit per clock through a serial input, or one whole word per strobe through the 36-bit write bus. Together with the two select bits, the same three straps also choose a default offset, and that value is written into both registers. After reset the offsets can be rewritten at any time through the chosen path. Either offset can be read back on the 36-bit parallel output word, whichever load mode is active. There is no serial readback.

Top module: `flag_ofs_loader`

## Requirements
- R1: While `rst_ni` is low, each clock loads both offsets with a default set by the code k = {`ld_i`,`fsel_i[1]`,`fsel_i[0]`}, read as an unsigned number 0..7. For DEPTH >= 4096 the default is 2^(10-k)-1, so 1023 for k=0 down to 7 for k=7. For smaller depths it is 2^(9-k)-1. The default never exceeds DEPTH-1.
- R2: `serial_mode_o` takes the value of `ld_i` as sampled during reset. It stays unchanged until the next reset.
- R3: In serial mode, every clock with `load_en_i` high shifts in `sdata_i`. A full load is 2*OW bits (OW = clog2(DEPTH)): first the bits of `n`, LSB first, then the bits of `m`, LSB first. Both offsets change at the edge that captures the final bit, and not before.
- R4: In parallel mode, the first `load_en_i` strobe after reset writes `wdata_i` into `n`, the next one writes it into `m`, and later strobes keep alternating. The new value is visible one clock after the strobe.
- R5: With `load_en_i` low, both offsets hold their values. `wdata_i` has no effect in serial mode, and `sdata_i` has no effect in parallel mode.
- R6: A parallel write of any value at or above DEPTH stores DEPTH-1. Both offsets always stay below DEPTH.
- R7: A `rd_ofs_i` pulse puts the current `n` (on the first read after reset) or `m` (on the next read), zero-extended to 36 bits, on `rdata_o` one clock later. Later reads keep alternating. This works in both modes, and `rdata_o` holds its value between reads.
- R8: Reset clears `rdata_o` to 0, points both the write alternation and the read alternation back at `n`, and discards any partial serial load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| ld_i | input | 1 | Strap sampled in reset: 1 selects serial load, 0 selects parallel load; also the top bit of the default code |
| fsel_i | input | 2 | Default offset select straps, sampled in reset |
| load_en_i | input | 1 | Load enable: a shift in serial mode, a write strobe in parallel mode |
| sdata_i | input | 1 | Serial offset data bit |
| wdata_i | input | 36 | Parallel offset write word |
| rd_ofs_i | input | 1 | Offset readback strobe |
| rdata_o | output | 36 | Readback word |
| n_o | output | OW | Almost-empty offset |
| m_o | output | OW | Almost-full offset |
| serial_mode_o | output | 1 | 1 when serial loading was selected at reset |

## Verification
The assertions assume the straps do not change in the last clock before reset is released, and that `load_en_i` and `rd_ofs_i` are clean single-clock-sampled levels. The bench meets both conditions: it changes straps and strobes only on falling edges, and it holds the straps steady through several reset clocks. The random phases draw write words from across the full 36-bit range, so clamping gets exercised. They run in both modes, so the ignored data input is always toggling. Serial loads are run across many full 2*OW-bit frames, with strobes interleaved, so the mid-frame hold checks see partially loaded shift states.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;
  localparam int unsigned DATA_W = 36;

  // default offset: 2^(top_exp-code)-1, clamped to depth-1
  function automatic int unsigned dflt_ofs(input logic [2:0] code,
                                           input int unsigned top_exp,
                                           input int unsigned depth);
    int unsigned v;
    v = (32'd1 << (top_exp - 32'(code))) - 32'd1;
    if (v > depth - 1) v = depth - 1;
    return v;
  endfunction
endpackage

// File: rtl/flag_ofs_strap.sv
module flag_ofs_strap #(
  parameter int unsigned DEPTH = 16384,
  parameter int unsigned OW    = 14
) (
  input  logic          ld_i,
  input  logic [1:0]    fsel_i,
  output logic [OW-1:0] dflt_o
);
  import flag_ofs_pkg::*;

  logic [31:0] top_exp;
  logic [31:0] val;

  generate
    if (DEPTH >= 4096) begin : g_deep
      assign top_exp = 32'd10;
    end else begin : g_shallow
      assign top_exp = 32'd9;
    end
  endgenerate

  assign val    = dflt_ofs({ld_i, fsel_i}, top_exp, DEPTH);
  assign dflt_o = val[OW-1:0];
endmodule

// File: rtl/flag_ofs_serial.sv
module flag_ofs_serial #(
  parameter int unsigned OW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          bit_i,
  output logic          commit_o,
  output logic [OW-1:0] n_o,
  output logic [OW-1:0] m_o
);
  localparam int unsigned SW = 2 * OW;
  localparam int unsigned CW = $clog2(SW + 1);
  localparam logic [CW-1:0] LAST = CW'(SW - 1);

  logic [SW-1:0] sh_q, sh_nxt;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign sh_nxt   = {bit_i, sh_q[SW-1:1]};
  assign last     = (cnt_q == LAST);
  assign commit_o = en_i & last;
  assign n_o      = sh_nxt[OW-1:0];
  assign m_o      = sh_nxt[SW-1:OW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en_i) begin
      sh_q  <= sh_nxt;
      cnt_q <= last ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/flag_ofs_par.sv
module flag_ofs_par #(
  parameter int unsigned DEPTH = 16384,
  parameter int unsigned OW    = 14,
  parameter int unsigned DW    = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wr_n_o,
  output logic          wr_m_o,
  output logic [OW-1:0] val_o
);
  localparam logic [DW-1:0] LIM_W = DW'(DEPTH - 1);
  localparam logic [OW-1:0] LIM_O = OW'(DEPTH - 1);

  logic tog_q;

  assign val_o  = (wdata_i > LIM_W) ? LIM_O : wdata_i[OW-1:0];
  assign wr_n_o = en_i & ~tog_q;
  assign wr_m_o = en_i & tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tog_q <= 1'b0;
    else if (en_i) tog_q <= ~tog_q;
  end
endmodule

// File: rtl/flag_ofs_rdbk.sv
module flag_ofs_rdbk #(
  parameter int unsigned OW = 14,
  parameter int unsigned DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [OW-1:0] n_i,
  input  logic [OW-1:0] m_i,
  output logic [DW-1:0] rdata_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q   <= 1'b0;
      rdata_o <= '0;
    end else if (rd_i) begin
      tog_q   <= ~tog_q;
      rdata_o <= DW'(tog_q ? m_i : n_i);
    end
  end
endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader #(
  parameter int unsigned DEPTH = 16384
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  ld_i,
  input  logic [1:0]                            fsel_i,
  input  logic                                  load_en_i,
  input  logic                                  sdata_i,
  input  logic [flag_ofs_pkg::DATA_W-1:0]       wdata_i,
  input  logic                                  rd_ofs_i,
  output logic [flag_ofs_pkg::DATA_W-1:0]       rdata_o,
  output logic [$clog2(DEPTH)-1:0]              n_o,
  output logic [$clog2(DEPTH)-1:0]              m_o,
  output logic                                  serial_mode_o
);
  localparam int unsigned OW = $clog2(DEPTH);
  localparam int unsigned DW = flag_ofs_pkg::DATA_W;
  localparam logic [OW-1:0] MAXV = OW'(DEPTH - 1);

  logic [OW-1:0] dflt;
  logic [OW-1:0] n_q, m_q;
  logic          mode_q;
  logic          ser_en, par_en;
  logic          ser_commit;
  logic [OW-1:0] ser_n, ser_m, ser_n_c, ser_m_c;
  logic          par_wr_n, par_wr_m;
  logic [OW-1:0] par_val;

  flag_ofs_strap #(.DEPTH(DEPTH), .OW(OW)) u_strap (
    .ld_i   (ld_i),
    .fsel_i (fsel_i),
    .dflt_o (dflt)
  );

  assign ser_en = load_en_i & mode_q;
  assign par_en = load_en_i & ~mode_q;

  flag_ofs_serial #(.OW(OW)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ser_en),
    .bit_i    (sdata_i),
    .commit_o (ser_commit),
    .n_o      (ser_n),
    .m_o      (ser_m)
  );

  // only matters when DEPTH is not a power of two
  assign ser_n_c = (ser_n > MAXV) ? MAXV : ser_n;
  assign ser_m_c = (ser_m > MAXV) ? MAXV : ser_m;

  flag_ofs_par #(.DEPTH(DEPTH), .OW(OW), .DW(DW)) u_par (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (par_en),
    .wdata_i (wdata_i),
    .wr_n_o  (par_wr_n),
    .wr_m_o  (par_wr_m),
    .val_o   (par_val)
  );

  // straps are captured on every edge while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= dflt;
      m_q    <= dflt;
      mode_q <= ld_i;
    end else if (ser_commit) begin
      n_q <= ser_n_c;
      m_q <= ser_m_c;
    end else begin
      if (par_wr_n) n_q <= par_val;
      if (par_wr_m) m_q <= par_val;
    end
  end

  flag_ofs_rdbk #(.OW(OW), .DW(DW)) u_rdbk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_ofs_i),
    .n_i     (n_q),
    .m_i     (m_q),
    .rdata_o (rdata_o)
  );

  assign n_o           = n_q;
  assign m_o           = m_q;
  assign serial_mode_o = mode_q;
endmodule

// File: rtl/flag_ofs_loader_chk.sv
module flag_ofs_loader_chk #(
  parameter int unsigned DEPTH = 16384,
  parameter int unsigned OW    = 14,
  parameter int unsigned DW    = 36
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_en_i,
  input logic          rd_ofs_i,
  input logic          serial_mode_o,
  input logic [OW-1:0] n_o,
  input logic [OW-1:0] m_o,
  input logic [DW-1:0] rdata_o
);
  localparam int unsigned CW = $clog2(2 * OW + 1);
  localparam logic [CW-1:0] LAST = CW'(2 * OW - 1);

  logic          seen_q;
  logic          rt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      rt_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      seen_q <= 1'b1;
      if (rd_ofs_i) rt_q <= ~rt_q;
      if (serial_mode_o && load_en_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  end

  a_r6_n_below_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(n_o) < DEPTH);
  a_r6_m_below_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(m_o) < DEPTH);
  a_r2_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> $stable(serial_mode_o));
  a_r5_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !load_en_i) |=> ($stable(n_o) && $stable(m_o)));
  a_r3_no_early_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serial_mode_o && load_en_i && cnt_q != LAST) |=> ($stable(n_o) && $stable(m_o)));
  a_r7_first_read_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ofs_i && !rt_q) |=> (rdata_o == DW'($past(n_o))));
  a_r7_second_read_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ofs_i && rt_q) |=> (rdata_o == DW'($past(m_o))));
  a_r7_rdata_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !rd_ofs_i) |=> $stable(rdata_o));
endmodule

bind flag_ofs_loader flag_ofs_loader_chk #(.DEPTH(DEPTH), .OW(OW), .DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .load_en_i     (load_en_i),
  .rd_ofs_i      (rd_ofs_i),
  .serial_mode_o (serial_mode_o),
  .n_o           (n_o),
  .m_o           (m_o),
  .rdata_o       (rdata_o)
);

// File: tb/flag_ofs_loader_bench.sv
module flag_ofs_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16384;
  localparam int OW = $clog2(DEPTH);
  localparam int DW = 36;
  localparam int SW = 2 * OW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ld_i = 1'b0;
  logic [1:0]    fsel_i = 2'b00;
  logic          load_en_i = 1'b0;
  logic          sdata_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic          rd_ofs_i = 1'b0;
  logic [DW-1:0] rdata_o;
  logic [OW-1:0] n_o, m_o;
  logic          serial_mode_o;

  flag_ofs_loader #(.DEPTH(DEPTH)) u_flag_ofs_loader (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_i), .fsel_i(fsel_i),
    .load_en_i(load_en_i), .sdata_i(sdata_i), .wdata_i(wdata_i),
    .rd_ofs_i(rd_ofs_i), .rdata_o(rdata_o), .n_o(n_o), .m_o(m_o),
    .serial_mode_o(serial_mode_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] e_n, e_m, e_rd;
  logic          e_mode, e_wt, e_rt;
  logic [SW-1:0] e_sh;
  int            e_cnt;

  function automatic logic [DW-1:0] dflt(input int code);
    int v;
    v = (1 << (10 - code)) - 1;
    if (v > DEPTH - 1) v = DEPTH - 1;
    return DW'(v);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "n_o", DW'(n_o), e_n);
    chk(req, "m_o", DW'(m_o), e_m);
    chk(req, "rdata_o", rdata_o, e_rd);
    chk("R2", "serial_mode_o", DW'(serial_mode_o), DW'(e_mode));
  endtask

  task automatic do_reset(input logic ld, input logic [1:0] fs, input string req);
    @(negedge clk_i);
    ld_i = ld; fsel_i = fs; rst_ni = 1'b0;
    load_en_i = 1'b0; rd_ofs_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    e_n = dflt(int'({ld, fs})); e_m = e_n; e_rd = '0;
    e_mode = ld; e_wt = 1'b0; e_rt = 1'b0; e_sh = '0; e_cnt = 0;
    #1;
    check_all(req);
  endtask

  // called at a falling edge; drives, advances model, checks at next falling edge
  task automatic cycle(input logic le, input logic sd, input logic [DW-1:0] wd,
                       input logic rd, input string req);
    logic [DW-1:0] v;
    load_en_i = le; sdata_i = sd; wdata_i = wd; rd_ofs_i = rd;
    if (rd) begin
      e_rd = e_rt ? e_m : e_n;
      e_rt = ~e_rt;
    end
    if (le) begin
      if (e_mode) begin
        e_sh = {sd, e_sh[SW-1:1]};
        if (e_cnt == SW - 1) begin
          e_n = DW'(e_sh[OW-1:0]);
          e_m = DW'(e_sh[SW-1:OW]);
          e_cnt = 0;
        end else e_cnt++;
      end else begin
        v = (wd >= DW'(DEPTH)) ? DW'(DEPTH - 1) : wd;
        if (!e_wt) e_n = v; else e_m = v;
        e_wt = ~e_wt;
      end
    end
    @(negedge clk_i);
    check_all(req);
  endtask

  function automatic logic [DW-1:0] rnd_word();
    logic [DW-1:0] w;
    w = {4'($urandom), $urandom};
    if ($urandom % 3 != 0) w = DW'($urandom % DEPTH);
    return w;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [OW-1:0] pn, pm;
    logic [SW-1:0] frame;
    void'($urandom(32'd4242));

    // R1 / R2 / R8: every strap code
    for (int k = 0; k < 8; k++) begin
      logic [2:0] c;
      c = 3'(k);
      do_reset(c[2], c[1:0], "R1");
      chk("R8", "rdata_o after reset", rdata_o, '0);
    end

    // R4 / R6 / R5 / R7 parallel directed
    do_reset(1'b0, 2'b01, "R1");
    cycle(1'b1, 1'b1, DW'(100), 1'b0, "R4");
    cycle(1'b1, 1'b0, DW'(200), 1'b0, "R4");
    cycle(1'b1, 1'b1, {DW{1'b1}}, 1'b0, "R6");
    cycle(1'b1, 1'b1, DW'(DEPTH), 1'b0, "R6");
    cycle(1'b1, 1'b0, DW'(DEPTH - 1), 1'b0, "R6");
    cycle(1'b0, 1'b1, DW'(5), 1'b0, "R5");
    cycle(1'b0, 1'b0, DW'(0), 1'b1, "R7");
    cycle(1'b0, 1'b0, DW'(0), 1'b1, "R7");
    cycle(1'b0, 1'b0, DW'(0), 1'b0, "R7");
    cycle(1'b1, 1'b0, DW'(0), 1'b1, "R7");

    // R8: toggles return to n after reset
    do_reset(1'b0, 2'b11, "R8");
    cycle(1'b0, 1'b0, DW'(0), 1'b1, "R8");
    cycle(1'b1, 1'b0, DW'(77), 1'b0, "R8");

    // parallel random
    for (int i = 0; i < 3000; i++)
      cycle(1'($urandom), 1'($urandom), rnd_word(), 1'($urandom % 4 == 0), "R4");

    // R3 serial directed frame, wdata toggling (R5)
    do_reset(1'b1, 2'b10, "R1");
    pn = OW'(16'h1234); pm = OW'(16'h2abc);
    frame = {pm, pn};
    for (int b = 0; b < SW; b++)
      cycle(1'b1, frame[b], {DW{1'b1}}, 1'b0, "R3");
    chk("R3", "n_o after frame", DW'(n_o), DW'(pn));
    chk("R3", "m_o after frame", DW'(m_o), DW'(pm));
    cycle(1'b0, 1'b1, DW'(9), 1'b1, "R7");
    cycle(1'b0, 1'b0, DW'(9), 1'b1, "R7");

    // R8: partial serial frame discarded by reset
    for (int b = 0; b < 5; b++) cycle(1'b1, 1'b1, '0, 1'b0, "R3");
    do_reset(1'b1, 2'b00, "R8");
    for (int b = 0; b < SW; b++) cycle(1'b1, 1'($urandom), '0, 1'b0, "R8");

    // serial random
    for (int i = 0; i < 4000; i++)
      cycle(1'($urandom), 1'($urandom), rnd_word(), 1'($urandom % 4 == 0), "R3");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule